// File: doc/BRIEF.md
# Shared-Pin Ready and Data Serial Transmitter

This block is the output stage of a converter that has a single digital pin for two jobs. It runs in fixed frames of 384 master clocks. In the first 36 clocks of each frame the pin carries a ready signal. In the remaining 348 clocks the pin carries the conversion result, shifted out one bit at a time and paced by a serial clock that the reading device supplies.

The ready part of a frame has three steps. First the pin sits high for 24 clocks. During the last 6 of those clocks, the most recent result word is copied into the output shift register, most significant part first. Next the pin drops low for 6 clocks. It then returns high for 6 clocks. After that the pin enters data mode and presents the most significant bit of the result. Each falling edge of the serial clock moves the pin on to the next bit.

The upstream logic hands over a 24-bit result with a one-cycle load strobe. Whatever word was loaded last before the copy window is the word sent in that frame. A flag marks the first five frames after reset as carrying unusable data. From the sixth frame on, the flag reports the data as valid.

Top module: `ssr_ready_data_tx`

## Requirements
- R1: While `rst` is high at a rising clock edge, the design is in its reset state after that edge: frame position 0, pin high, `result_valid` low, and both the shift register and the stored result cleared to zero. The cycle after reset is released is position 0, and each later clock advances the position by one.
- R2: The frame repeats every 384 clocks. The low ready pulse begins at position 24 of every frame.
- R3: For positions 0 to 23 of each frame, the pin is high.
- R4: For positions 24 to 29 the pin is low. For positions 30 to 35 it is high again.
- R5: From position 36 to the end of the frame, the pin shows bit 23 of the shift register.
- R6: In data mode, a falling edge of `sclk` moves the pin to the next lower result bit. The new bit appears 3 master clocks after the falling edge is first sampled. After 24 such edges the pin reads 0 for the rest of the frame.
- R7: If `sclk` does not toggle during data mode, the pin keeps showing bit 23 of the result until the next frame begins.
- R8: Falling edges of `sclk` that occur during positions 0 to 35 are ignored. They consume no bits.
- R9: `result_valid` is low during the first five frames after reset. It is high from the sixth frame on, until the next reset.
- R10: When `res_load` is high at a clock edge, `res_data` is stored. During positions 18 to 23, the stored word is copied into the shift register, 4 bits per clock starting with the top bits. If no new load arrives, the same word is sent again in the next frame.
- R11: A reset asserted in the middle of a frame restarts the frame at position 0 and clears `result_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| res_load | input | 1 | One-cycle strobe: store `res_data` |
| res_data | input | 24 | Conversion result, bit 23 is sent first |
| sclk | input | 1 | Serial clock from the reader, asynchronous to `clk` |
| dout_rdy | output | 1 | Shared pin: ready pulse pattern, then serial data |
| result_valid | output | 1 | High once the discarded start-up frames are over |

## Verification
The assertions check the frame-to-frame behaviour on every cycle:
- the position wraps back to 0 after the last clock of a frame;
- the pin falls and rises at the edges of the ready pulse;
- the pin holds steady in data mode when no serial edge arrives;
- serial edges are ignored before the copy window;
- the valid flag, once set, stays set;
- reset leaves the design in its reset state.

Some behaviour can only be shown by the bench scenarios. These are the exact bit order, the three-clock latency from a serial edge to the new bit, the zero fill after the last bit, which word wins when loads and frames interleave, and the moment `result_valid` rises after exactly five frames.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    // Default frame timing, in master clocks
    localparam int FRAME_CLKS_D = 384;
    localparam int READY_CLKS_D = 36;
    localparam int PULSE_CLKS_D = 6;
    localparam int WRITE_CLKS_D = 6;

    // Default data and start-up settings
    localparam int DATA_W_D     = 24;
    localparam int DISCARD_D    = 5;
    localparam int SYNC_D       = 2;

    // What the shared pin is doing at a given frame position
    typedef enum logic [1:0] {
        PH_HOLD,
        PH_LOW,
        PH_ANNOUNCE,
        PH_DATA
    } phase_e;

    // Per-cycle control decoded from the frame position
    typedef struct packed {
        phase_e phase;
        logic   wr_en;
        logic   last_pos;
    } frame_ctl_t;

    // Ready phase = hold (high) + low pulse + announce (high), then data
    function automatic phase_e phase_of(input int pos, input int ready, input int pulse);
        int hold;
        hold = ready - 2 * pulse;
        if (pos < hold)
            return PH_HOLD;
        else if (pos < hold + pulse)
            return PH_LOW;
        else if (pos < ready)
            return PH_ANNOUNCE;
        else
            return PH_DATA;
    endfunction

endpackage

// File: rtl/ssr_frame_timer.sv
module ssr_frame_timer
    import ssr_pkg::*;
#(
    parameter int FRAME_CLKS = FRAME_CLKS_D,
    parameter int READY_CLKS = READY_CLKS_D,
    parameter int PULSE_CLKS = PULSE_CLKS_D,
    parameter int WRITE_CLKS = WRITE_CLKS_D,
    parameter int DISCARD    = DISCARD_D
) (
    input  logic                          clk,
    input  logic                          rst,
    output logic [$clog2(FRAME_CLKS)-1:0] pos,
    output frame_ctl_t                    ctl,
    output logic [$clog2(WRITE_CLKS)-1:0] wr_idx,
    output logic                          frame_valid
);

    localparam int CNT_W = $clog2(FRAME_CLKS);
    localparam int IDX_W = $clog2(DISCARD + 1);
    localparam int WI_W  = $clog2(WRITE_CLKS);
    localparam int HOLD  = READY_CLKS - 2 * PULSE_CLKS;
    localparam int WSTRT = HOLD - WRITE_CLKS;

    // Typed copies of the limits, so comparisons line up in width
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_CLKS - 1);
    localparam logic [CNT_W-1:0] W_LO     = CNT_W'(WSTRT);
    localparam logic [CNT_W-1:0] W_HI     = CNT_W'(HOLD - 1);
    localparam logic [IDX_W-1:0] DISC     = IDX_W'(DISCARD);

    logic [IDX_W-1:0] frame_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= '0;
            frame_idx <= '0;
        end else if (pos == LAST_POS) begin
            pos <= '0;
            if (frame_idx != DISC)
                frame_idx <= frame_idx + 1'b1;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    always_comb begin
        ctl.phase    = phase_of(int'(pos), READY_CLKS, PULSE_CLKS);
        ctl.wr_en    = (pos >= W_LO) && (pos <= W_HI);
        ctl.last_pos = (pos == LAST_POS);
    end

    assign wr_idx      = WI_W'(pos - W_LO);
    assign frame_valid = (frame_idx == DISC);

endmodule

// File: rtl/ssr_sclk_fall.sv
module ssr_sclk_fall #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronizer chain: stage 0 samples the raw serial clock
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= sclk;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[s] <= 1'b0;
                    else     sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    // One more register gives the previous synchronized value
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/ssr_out_shifter.sv
module ssr_out_shifter #(
    parameter int DATA_W     = 24,
    parameter int WRITE_CLKS = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [DATA_W-1:0]             data,
    input  logic                          wr_en,
    input  logic [$clog2(WRITE_CLKS)-1:0] wr_idx,
    input  logic                          shift_en,
    output logic [DATA_W-1:0]             shreg
);

    localparam int CHUNK_W = DATA_W / WRITE_CLKS;
    localparam int WI_W    = $clog2(WRITE_CLKS);

    logic [DATA_W-1:0] pending;
    logic [DATA_W-1:0] shreg_nxt;

    // Copy one chunk per write clock (top chunk first), or shift in data mode
    always_comb begin
        shreg_nxt = shreg;
        if (wr_en) begin
            for (int k = 0; k < WRITE_CLKS; k++) begin
                if (wr_idx == WI_W'(k))
                    shreg_nxt[DATA_W-1-k*CHUNK_W -: CHUNK_W] =
                        pending[DATA_W-1-k*CHUNK_W -: CHUNK_W];
            end
        end else if (shift_en) begin
            shreg_nxt = {shreg[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            shreg   <= '0;
        end else begin
            if (load)
                pending <= data;
            shreg <= shreg_nxt;
        end
    end

endmodule

// File: rtl/ssr_ready_data_tx.sv
module ssr_ready_data_tx
    import ssr_pkg::*;
#(
    parameter int FRAME_CLKS  = FRAME_CLKS_D,
    parameter int READY_CLKS  = READY_CLKS_D,
    parameter int PULSE_CLKS  = PULSE_CLKS_D,
    parameter int WRITE_CLKS  = WRITE_CLKS_D,
    parameter int DATA_W      = DATA_W_D,
    parameter int DISCARD     = DISCARD_D,
    parameter int SYNC_STAGES = SYNC_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_load,
    input  logic [DATA_W-1:0] res_data,
    input  logic              sclk,
    output logic              dout_rdy,
    output logic              result_valid
);

    localparam int CNT_W = $clog2(FRAME_CLKS);
    localparam int WI_W  = $clog2(WRITE_CLKS);

    logic [CNT_W-1:0]  pos;
    frame_ctl_t        ctl;
    phase_e            phase;
    logic [WI_W-1:0]   wr_idx;
    logic              frame_valid;
    logic              sclk_fall;
    logic              shift_en;
    logic [DATA_W-1:0] shreg;

    ssr_frame_timer #(
        .FRAME_CLKS (FRAME_CLKS),
        .READY_CLKS (READY_CLKS),
        .PULSE_CLKS (PULSE_CLKS),
        .WRITE_CLKS (WRITE_CLKS),
        .DISCARD    (DISCARD)
    ) i_timer (
        .clk         (clk),
        .rst         (rst),
        .pos         (pos),
        .ctl         (ctl),
        .wr_idx      (wr_idx),
        .frame_valid (frame_valid)
    );

    ssr_sclk_fall #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .fall (sclk_fall)
    );

    ssr_out_shifter #(
        .DATA_W     (DATA_W),
        .WRITE_CLKS (WRITE_CLKS)
    ) i_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (res_load),
        .data     (res_data),
        .wr_en    (ctl.wr_en),
        .wr_idx   (wr_idx),
        .shift_en (shift_en),
        .shreg    (shreg)
    );

    assign phase    = ctl.phase;
    // Serial edges only move data while the pin is in data mode
    assign shift_en = (phase == PH_DATA) && sclk_fall;

    always_comb begin
        unique case (phase)
            PH_HOLD:     dout_rdy = 1'b1;
            PH_LOW:      dout_rdy = 1'b0;
            PH_ANNOUNCE: dout_rdy = 1'b1;
            default:     dout_rdy = shreg[DATA_W-1];
        endcase
    end

    assign result_valid = frame_valid;

endmodule

// File: rtl/ssr_tx_checker.sv
module ssr_tx_checker
    import ssr_pkg::*;
#(
    parameter int FRAME_CLKS = FRAME_CLKS_D,
    parameter int READY_CLKS = READY_CLKS_D,
    parameter int PULSE_CLKS = PULSE_CLKS_D,
    parameter int WRITE_CLKS = WRITE_CLKS_D,
    parameter int DATA_W     = DATA_W_D
) (
    input logic                          clk,
    input logic                          rst,
    input logic [$clog2(FRAME_CLKS)-1:0] pos,
    input phase_e                        phase,
    input logic                          fall,
    input logic [DATA_W-1:0]             shreg,
    input logic                          dout_rdy,
    input logic                          result_valid
);

    localparam int CNT_W = $clog2(FRAME_CLKS);
    localparam int HOLD  = READY_CLKS - 2 * PULSE_CLKS;

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_CLKS - 1);
    localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD - 1);
    localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(HOLD + PULSE_CLKS - 1);
    localparam logic [CNT_W-1:0] W_LO     = CNT_W'(HOLD - WRITE_CLKS);

    // R1: reset leaves the design at position 0 with the pin high and the flag low
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (rst || (pos == '0 && dout_rdy && !result_valid)));

    // R2: the position wraps back to 0 after the last clock of a frame
    assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (pos == LAST_POS) |=> (pos == '0));

    // R4: the pin falls when the low pulse starts and rises when it ends
    assert_pulse_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (pos == HOLD_END) |=> !dout_rdy);

    assert_pulse_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (pos == LOW_END) |=> dout_rdy);

    // R7: in data mode, without a serial edge the pin does not move
    assert_hold_no_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && pos != LAST_POS && !fall) |=> $stable(dout_rdy));

    // R8: serial edges before the copy window leave the shift register untouched
    assert_ready_ignores_R8: assert property (@(posedge clk) disable iff (rst)
        (pos < W_LO && fall) |=> $stable(shreg));

    // R9: once set, the valid flag stays set until the next reset
    assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> result_valid);

endmodule

bind ssr_ready_data_tx ssr_tx_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .pos          (pos),
    .phase        (phase),
    .fall         (sclk_fall),
    .shreg        (shreg),
    .dout_rdy     (dout_rdy),
    .result_valid (result_valid)
);

// File: tb/test_ssr_ready_data_tx.sv
module test_ssr_ready_data_tx;

    localparam int W     = 24;
    localparam int FRAME = 384;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         res_load = 1'b0;
    logic [W-1:0] res_data = '0;
    logic         sclk = 1'b0;
    logic         dout_rdy;
    logic         result_valid;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    started = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;   // 100 MHz

    ssr_ready_data_tx i_ssr_ready_data_tx (
        .clk          (clk),
        .rst          (rst),
        .res_load     (res_load),
        .res_data     (res_data),
        .sclk         (sclk),
        .dout_rdy     (dout_rdy),
        .result_valid (result_valid)
    );

    // Behavioural reference model, written from the requirements
    int           m_pos = 0;
    int           m_frame = 0;
    int           edge_n = 0;
    bit           m_rst = 1;
    logic [W-1:0] m_bits = '0;
    logic [W-1:0] m_pend = '0;
    logic         m_prev_sclk = 1'b0;
    int           due_q[$];

    always @(posedge clk) begin
        bit do_shift;
        edge_n++;
        started = 1;
        m_rst = rst;
        if (rst) begin
            m_pos = 0;
            m_frame = 0;
            m_bits = '0;
            m_pend = '0;
            m_prev_sclk = 1'b0;
            due_q.delete();
        end else begin
            do_shift = 0;
            if (due_q.size() > 0 && due_q[0] == edge_n) begin
                void'(due_q.pop_front());
                do_shift = (m_pos >= 36);          // R8: ignored in ready phase
            end
            if (do_shift) m_bits = m_bits << 1;   // R6
            if (m_pos == 23) m_bits = m_pend;     // R10: copy finishes
            if (res_load) m_pend = res_data;
            if (m_prev_sclk && !sclk) due_q.push_back(edge_n + 2);
            m_prev_sclk = sclk;
            if (m_pos == FRAME - 1) begin
                m_pos = 0;
                if (m_frame < 5) m_frame++;
            end else begin
                m_pos++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at pos %0d: actual %0b expected %0b",
                     tag, what, m_pos, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        logic  exp_pin;
        logic  exp_val;
        string tg;
        string vt;
        if (started && !done) begin
            if (m_pos < 24)      exp_pin = 1'b1;
            else if (m_pos < 30) exp_pin = 1'b0;
            else if (m_pos < 36) exp_pin = 1'b1;
            else                 exp_pin = m_bits[W-1];
            exp_val = (m_frame >= 5);
            if (m_rst)             tg = (cur_tag == "R11") ? "R11" : "R1";
            else if (m_pos == 24)  tg = "R2";
            else if (m_pos < 24)   tg = "R3";
            else if (m_pos < 36)   tg = "R4";
            else                   tg = cur_tag;
            vt = m_rst ? tg : "R9";
            check(dout_rdy === exp_pin, tg, "dout_rdy", dout_rdy, exp_pin);
            check(result_valid === exp_val, vt, "result_valid", result_valid, exp_val);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pos(input int p);
        do @(negedge clk); while (m_pos != p || m_rst);
    endtask

    task automatic sclk_pulses(input int n, input int half);
        repeat (n) begin
            sclk = 1'b1;
            tick(half);
            sclk = 1'b0;
            tick(half);
        end
    endtask

    task automatic load_word(input logic [W-1:0] w);
        res_data = w;
        res_load = 1'b1;
        tick(1);
        res_load = 1'b0;
    endtask

    initial begin
        cur_tag = "R1";
        tick(4);
        rst = 1'b0;
        // Frame 0: load before the copy window, no serial clock (R10, R7)
        tick(2);
        cur_tag = "R10";
        load_word(24'hA5C3F1);
        cur_tag = "R7";
        wait_pos(FRAME - 1);
        // Frame 1: 26 falling edges, all bits plus zero fill (R6)
        cur_tag = "R6";
        wait_pos(40);
        sclk_pulses(26, 4);
        wait_pos(FRAME - 1);
        // Frame 2: edges during the ready phase are ignored (R8), word repeats
        cur_tag = "R8";
        wait_pos(2);
        sclk_pulses(3, 4);
        wait_pos(200);
        load_word(24'h3C5A96);
        wait_pos(FRAME - 1);
        // Frame 3: new word appears; partial read then hold (R10)
        cur_tag = "R10";
        wait_pos(50);
        sclk_pulses(12, 3);
        wait_pos(FRAME - 1);
        // Frame 4: data mode shows the register top bit (R5)
        cur_tag = "R5";
        wait_pos(100);
        load_word(24'h800001);
        wait_pos(FRAME - 1);
        // Frame 5: first valid frame, full read (R9)
        cur_tag = "R9";
        wait_pos(60);
        sclk_pulses(24, 5);
        wait_pos(FRAME - 1);
        // Frame 6: plain repeat of the frame timing (R2)
        cur_tag = "R2";
        wait_pos(FRAME - 1);
        // Frame 7: reset mid-frame restarts everything (R11)
        cur_tag = "R11";
        wait_pos(150);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        cur_tag = "R9";
        wait_pos(FRAME - 1);
        wait_pos(FRAME - 1);
        wait_pos(40);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule